// File: doc/BRIEF.md
# Posit Field Decoder

This block takes a single posit word and splits it into its parts. The parts are the sign, the signed regime value, the exponent bits, the significand with its implicit leading one, and a combined binary scale. Two flags mark the zero word and the single exceptional value, Not-a-Real. The regime is run-length encoded and has a variable length, so the positions of the exponent and fraction depend on each word's value. A leading-run count therefore fixes where the remaining fields start. A word whose sign bit is set is first replaced by its two's complement, and only then are its fields read.

The width `N` and exponent size `ES` are parameters. The supported pairs include 32/2, 16/1 and 8/0. The input is a valid/word pair. The output is a valid flag together with the decoded fields. Parameter `PIPE` selects one output register (latency of one clock) or a purely combinational path. The block is meant to sit in front of arithmetic units that need aligned scale and significand values. It does no arithmetic, rounding or encoding itself.

Top module: `posit_field_decoder`

## Requirements
- R1: An input word whose bits are all zero gives out_zero=1 and out_nar=0, and regime, exponent, significand and scale are all zero.
- R2: An input word with only its top bit set gives out_nar=1, out_zero=0 and out_sign=1, and regime, exponent, significand and scale are all zero.
- R3: When the bit just below the sign (after any complementing) is one, a run of k equal bits followed by a different bit gives a regime of k-1.
- R4: When the bit just below the sign is zero, a run of k zeros followed by a one gives a regime of -k.
- R5: out_sign equals the input's top bit. When that bit is set and the word is not Not-a-Real, the fields are read from the two's complement of the whole word, so a word and its negation decode to the same regime, exponent and significand.
- R6: The ES bits after the regime's terminating bit form the exponent, most significant bit first. Exponent bits that fall below bit 0 read as zero. With ES=0 the exponent output is a single bit held at zero.
- R7: The significand output is N-2 bits wide. Its top bit is the implicit one, followed by the fraction bits left-justified, with zeros filling below the last fraction bit.
- R8: out_scale equals regime*2^ES + exponent, as a signed value.
- R9: The regime run is capped at N-1 bits. The all-ones body gives regime N-2 and the body 0..01 gives regime -(N-1)+1. At 32/2, 0x7FFFFFFF gives regime 30 (scale 120) and 0x00000001 gives regime -30 (scale -120).
- R10: With PIPE=1, out_valid and the fields appear one clock after in_valid and the word are presented. A cycle with in_valid=0 gives out_valid=0 one clock later. Reset clears out_valid and all fields.
- R11: The decode is correct for the parameter pairs N=32/ES=2, N=16/ES=1 and N=8/ES=0. At 32/2, 0x40000000 decodes to regime 0, exponent 0, significand 0x20000000 and scale 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_word | input | N | Posit word to decode |
| out_valid | output | 1 | Decoded fields are valid |
| out_sign | output | 1 | Sign bit of the input |
| out_zero | output | 1 | Input was the zero word |
| out_nar | output | 1 | Input was Not-a-Real |
| out_regime | output | $clog2(N)+1 | Signed regime value |
| out_exp | output | max(ES,1) | Exponent bits |
| out_mant | output | N-2 | Implicit one followed by the left-justified fraction |
| out_scale | output | $clog2(N)+1+ES | Signed combined scale |

## Verification
The hardest words to produce are those whose regime is so long that it eats part or all of the exponent. In these words the exponent must be padded with zeros rather than taken from stale low bits. The same difficulty holds when this happens to a negative word, where the complement moves the run boundary. The stimulus reaches these cases in three ways. It sweeps every 8-bit word. It sends hand-picked 32-bit words whose terminating bit lies in the last one or two positions. It sends the negation of each of those words. Every result is compared against a bit-serial model of the field layout that the bench computes on its own.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Class of a posit word, known before field extraction.
    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_ZERO   = 2'd1,
        KIND_NAR    = 2'd2
    } kind_e;

endpackage

// File: rtl/pfd_magnitude.sv
// Classifies the word and produces its magnitude (two's complement when negative).
module pfd_magnitude #(
    parameter int N = 32
) (
    input  logic [N-1:0]  word_i,
    output pfd_pkg::kind_e kind_o,
    output logic          sign_o,
    output logic [N-1:0]  mag_o
);
    logic tail_zero;

    always_comb begin
        sign_o    = word_i[N-1];
        tail_zero = ~|word_i[N-2:0];
        if (tail_zero) begin
            kind_o = sign_o ? pfd_pkg::KIND_NAR : pfd_pkg::KIND_ZERO;
        end else begin
            kind_o = pfd_pkg::KIND_NORMAL;
        end
        mag_o = sign_o ? (~word_i + N'(1)) : word_i;
    end
endmodule

// File: rtl/pfd_run_length.sv
// Counts the run of bits equal to the top bit of the body (capped at N-1).
module pfd_run_length #(
    parameter int N  = 32,
    localparam int CW = $clog2(N)
) (
    input  logic [N-2:0]  body_i,
    output logic          lead_o,
    output logic [CW-1:0] run_o
);
    logic [N-2:0] flipped;
    logic         hit;

    always_comb begin
        lead_o  = body_i[N-2];
        flipped = lead_o ? ~body_i : body_i;
        run_o   = CW'(N-1);
        hit     = 1'b0;
        for (int i = N-2; i >= 0; i--) begin
            if (!hit && flipped[i]) begin
                run_o = CW'(N-2-i);
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfd_field_split.sv
// Strips the regime and extracts exponent, fraction and combined scale.
module pfd_field_split #(
    parameter int N   = 32,
    parameter int ES  = 2,
    localparam int CW  = $clog2(N),
    localparam int RGW = CW + 1,
    localparam int EW  = (ES > 0) ? ES : 1,
    localparam int SCW = RGW + ES
) (
    input  logic [N-2:0]           body_i,
    input  logic                   lead_i,
    input  logic [CW-1:0]          run_i,
    output logic signed [RGW-1:0]  regime_o,
    output logic [EW-1:0]          exp_o,
    output logic [N-4:0]           frac_o,
    output logic signed [SCW-1:0]  scale_o
);
    logic [CW:0]           consumed;
    logic [N-2:0]          rest;
    logic signed [RGW-1:0] run_s;
    logic signed [SCW-1:0] regime_wide;

    always_comb begin
        consumed = {1'b0, run_i} + (CW+1)'(1);
        rest     = body_i << consumed;
        run_s    = $signed(RGW'(run_i));
        regime_o = lead_i ? (run_s - RGW'(1)) : (-run_s);
        frac_o   = (N-3)'((rest << ES) >> 2);
    end

    generate
        if (ES > 0) begin : g_exp
            always_comb exp_o = rest[N-2 -: ES];
        end else begin : g_noexp
            always_comb exp_o = '0;
        end
    endgenerate

    always_comb begin
        regime_wide = SCW'(regime_o);
        scale_o     = (regime_wide <<< ES) + $signed(SCW'(exp_o));
    end
endmodule

// File: rtl/posit_field_decoder.sv
module posit_field_decoder #(
    parameter int N    = 32,
    parameter int ES   = 2,
    parameter bit PIPE = 1'b1,
    localparam int CW  = $clog2(N),
    localparam int RGW = CW + 1,
    localparam int EW  = (ES > 0) ? ES : 1,
    localparam int MW  = N - 2,
    localparam int SCW = RGW + ES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [N-1:0]          in_word,
    output logic                  out_valid,
    output logic                  out_sign,
    output logic                  out_zero,
    output logic                  out_nar,
    output logic signed [RGW-1:0] out_regime,
    output logic [EW-1:0]         out_exp,
    output logic [MW-1:0]         out_mant,
    output logic signed [SCW-1:0] out_scale
);
    typedef struct packed {
        logic                  valid;
        logic                  sign;
        logic                  zero;
        logic                  nar;
        logic signed [RGW-1:0] regime;
        logic [EW-1:0]         expo;
        logic [MW-1:0]         mant;
        logic signed [SCW-1:0] scale;
    } dec_t;

    pfd_pkg::kind_e        kind;
    logic                  sign;
    logic [N-1:0]          mag;
    logic                  lead;
    logic [CW-1:0]         run;
    logic signed [RGW-1:0] regime;
    logic [EW-1:0]         expo;
    logic [N-4:0]          frac;
    logic signed [SCW-1:0] scale;
    dec_t                  dec_d;
    dec_t                  dec_o;

    pfd_magnitude #(.N(N)) u_mag (
        .word_i (in_word),
        .kind_o (kind),
        .sign_o (sign),
        .mag_o  (mag)
    );

    pfd_run_length #(.N(N)) u_run (
        .body_i (mag[N-2:0]),
        .lead_o (lead),
        .run_o  (run)
    );

    pfd_field_split #(.N(N), .ES(ES)) u_split (
        .body_i   (mag[N-2:0]),
        .lead_i   (lead),
        .run_i    (run),
        .regime_o (regime),
        .exp_o    (expo),
        .frac_o   (frac),
        .scale_o  (scale)
    );

    always_comb begin
        dec_d       = '0;
        dec_d.valid = in_valid;
        dec_d.sign  = sign;
        dec_d.zero  = (kind == pfd_pkg::KIND_ZERO);
        dec_d.nar   = (kind == pfd_pkg::KIND_NAR);
        if (kind == pfd_pkg::KIND_NORMAL) begin
            dec_d.regime = regime;
            dec_d.expo   = expo;
            dec_d.mant   = {1'b1, frac};
            dec_d.scale  = scale;
        end
    end

    generate
        if (PIPE) begin : g_reg
            dec_t dec_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dec_q <= '0;
                end else begin
                    dec_q <= dec_d;
                end
            end
            assign dec_o = dec_q;
        end else begin : g_comb
            assign dec_o = dec_d;
        end
    endgenerate

    assign out_valid  = dec_o.valid;
    assign out_sign   = dec_o.sign;
    assign out_zero   = dec_o.zero;
    assign out_nar    = dec_o.nar;
    assign out_regime = dec_o.regime;
    assign out_exp    = dec_o.expo;
    assign out_mant   = dec_o.mant;
    assign out_scale  = dec_o.scale;
endmodule

// File: rtl/posit_field_decoder_chk.sv
module posit_field_decoder_chk #(
    parameter int N    = 32,
    parameter int ES   = 2,
    parameter bit PIPE = 1'b1,
    localparam int CW  = $clog2(N),
    localparam int RGW = CW + 1,
    localparam int MW  = N - 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [N-1:0]          in_word,
    input logic                  out_valid,
    input logic                  out_sign,
    input logic                  out_zero,
    input logic                  out_nar,
    input logic signed [RGW-1:0] out_regime,
    input logic [MW-1:0]         out_mant
);
    localparam logic [N-1:0] NAR_WORD = {1'b1, {(N-1){1'b0}}};

    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_zero && out_nar));

    assert_special_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_zero || out_nar) |-> (out_mant == '0) && (out_regime == '0));

    assert_hidden_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero && !out_nar |-> out_mant[MW-1]);

    assert_regime_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_regime) >= -(N-1)) && (int'(out_regime) <= N-2));

    generate
        if (PIPE) begin : g_timed
            assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);

            assert_zero_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && (in_word == '0) |=> out_zero && !out_nar);

            assert_nar_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && (in_word == NAR_WORD) |=> out_nar && out_sign);

            assert_sign_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_sign == $past(in_word[N-1]));
        end
    endgenerate
endmodule

bind posit_field_decoder posit_field_decoder_chk #(.N(N), .ES(ES), .PIPE(PIPE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_sign   (out_sign),
    .out_zero   (out_zero),
    .out_nar    (out_nar),
    .out_regime (out_regime),
    .out_mant   (out_mant)
);

// File: tb/posit_field_decoder_bench.sv
`timescale 1ns/1ps
module posit_field_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [31:0] w32 = '0;
    logic [15:0] w16 = '0;
    logic [7:0]  w8  = '0;
    int          checks = 0;
    int          fails  = 0;

    always #10 clk = ~clk;

    logic              v32, s32, z32, n32;
    logic signed [5:0] r32;
    logic [1:0]        e32;
    logic [29:0]       m32;
    logic signed [7:0] c32;

    logic              v16, s16, z16, n16;
    logic signed [4:0] r16;
    logic [0:0]        e16;
    logic [13:0]       m16;
    logic signed [5:0] c16;

    logic              v8, s8, z8, n8;
    logic signed [3:0] r8;
    logic [0:0]        e8;
    logic [5:0]        m8;
    logic signed [3:0] c8;

    posit_field_decoder #(.N(32), .ES(2), .PIPE(1'b1)) u_posit_field_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_word(w32),
        .out_valid(v32), .out_sign(s32), .out_zero(z32), .out_nar(n32),
        .out_regime(r32), .out_exp(e32), .out_mant(m32), .out_scale(c32));

    posit_field_decoder #(.N(16), .ES(1), .PIPE(1'b1)) u_posit_field_decoder_16 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_word(w16),
        .out_valid(v16), .out_sign(s16), .out_zero(z16), .out_nar(n16),
        .out_regime(r16), .out_exp(e16), .out_mant(m16), .out_scale(c16));

    posit_field_decoder #(.N(8), .ES(0), .PIPE(1'b1)) u_posit_field_decoder_8 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_word(w8),
        .out_valid(v8), .out_sign(s8), .out_zero(z8), .out_nar(n8),
        .out_regime(r8), .out_exp(e8), .out_mant(m8), .out_scale(c8));

    // Bit-serial reference of the field layout.
    task automatic model(input int n, input int es, input logic [31:0] w,
                         output int sg, output int zr, output int nr, output int rg,
                         output int ex, output int mt, output int sc);
        logic [63:0] m;
        logic [63:0] v;
        int          k;
        int          pos;
        int          idx;
        logic        first;
        m  = (64'd1 << n) - 64'd1;
        v  = {32'd0, w} & m;
        sg = int'(v[n-1]);
        zr = (v == 64'd0) ? 1 : 0;
        nr = (v[n-1] && ((v & (m >> 1)) == 64'd0)) ? 1 : 0;
        rg = 0; ex = 0; mt = 0; sc = 0;
        if (zr == 0 && nr == 0) begin
            if (v[n-1]) v = (~v + 64'd1) & m;
            first = v[n-2];
            k = 0;
            for (int i = n-2; i >= 0; i--) begin
                if (v[i] != first) break;
                k++;
            end
            rg  = first ? k - 1 : -k;
            pos = n - 3 - k;
            for (int j = 0; j < es; j++) begin
                idx = pos - j;
                ex  = ex * 2 + ((idx >= 0) ? int'(v[idx]) : 0);
            end
            mt = 1;
            for (int t = 0; t < n - 3; t++) begin
                idx = pos - es - t;
                mt  = mt * 2 + ((idx >= 0) ? int'(v[idx]) : 0);
            end
            sc = rg * (1 << es) + ex;
        end
    endtask

    task automatic cmp(input string tag, input int n, input int es, input logic [31:0] w,
                       input int a_s, input int a_z, input int a_n, input int a_r,
                       input int a_e, input int a_m, input int a_c);
        int sg, zr, nr, rg, ex, mt, sc;
        model(n, es, w, sg, zr, nr, rg, ex, mt, sc);
        checks++;
        if (a_s != sg || a_z != zr || a_n != nr || a_r != rg || a_e != ex ||
            a_m != mt || a_c != sc) begin
            fails++;
            $display("FAIL %s n=%0d word=%h got s%0d z%0d nar%0d reg%0d exp%0d mant%h scale%0d expected s%0d z%0d nar%0d reg%0d exp%0d mant%h scale%0d",
                     tag, n, w, a_s, a_z, a_n, a_r, a_e, a_m, a_c, sg, zr, nr, rg, ex, mt, sc);
        end
    endtask

    task automatic check_val(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // Present words for one cycle, then check every width one clock later.
    task automatic apply(input string tag, input logic [31:0] a, input logic [15:0] b,
                         input logic [7:0] c);
        @(negedge clk);
        vld = 1'b1; w32 = a; w16 = b; w8 = c;
        @(negedge clk);
        check_val({tag, " valid"}, int'(v32 & v16 & v8), 1);
        cmp(tag, 32, 2, a, int'(s32), int'(z32), int'(n32), int'(r32), int'(e32), int'(m32), int'(c32));
        cmp(tag, 16, 1, {16'd0, b}, int'(s16), int'(z16), int'(n16), int'(r16), int'(e16), int'(m16), int'(c16));
        cmp(tag, 8, 0, {24'd0, c}, int'(s8), int'(z8), int'(n8), int'(r8), int'(e8), int'(m8), int'(c8));
    endtask

    task automatic t_reset;
        check_val("R10 reset valid", int'(v32 | v16 | v8), 0);
        check_val("R10 reset fields", int'(m32 != 0 || r32 != 0 || c32 != 0), 0);
    endtask

    task automatic t_one;
        apply("R11 one", 32'h4000_0000, 16'h4000, 8'h40);
        check_val("R11 one regime", int'(r32), 0);
        check_val("R11 one mant", int'(m32), 32'h2000_0000);
        check_val("R11 one scale", int'(c32), 0);
    endtask

    task automatic t_specials;
        apply("R1 zero", 32'h0, 16'h0, 8'h0);
        check_val("R1 zero flag", int'(z32 & z16 & z8), 1);
        apply("R2 nar", 32'h8000_0000, 16'h8000, 8'h80);
        check_val("R2 nar flag", int'(n32 & n16 & n8), 1);
    endtask

    task automatic t_regimes;
        apply("R3 ones run", 32'h7000_0000, 16'h7800, 8'h6c);
        check_val("R3 regime", int'(r32), 2);
        apply("R4 zeros run", 32'h0480_0000, 16'h0300, 8'h12);
        check_val("R4 regime", int'(r32), -4);
    endtask

    task automatic t_extremes;
        apply("R9 maxpos", 32'h7FFF_FFFF, 16'h7FFF, 8'h7F);
        check_val("R9 maxpos regime", int'(r32), 30);
        check_val("R9 maxpos scale", int'(c32), 120);
        apply("R9 minpos", 32'h0000_0001, 16'h0001, 8'h01);
        check_val("R9 minpos regime", int'(r32), -30);
        check_val("R9 minpos scale", int'(c32), -120);
    endtask

    task automatic t_truncated_exp;
        apply("R6 exp cut", 32'h7FFF_FFFD, 16'h7FFD, 8'h7D);
        check_val("R6 exp cut value", int'(e32), 2);
        check_val("R8 exp cut scale", int'(c32), 114);
        apply("R6 exp none", 32'h7FFF_FFFE, 16'h7FFE, 8'h7E);
        apply("R6 exp low", 32'h0000_0003, 16'h0003, 8'h03);
    endtask

    task automatic t_negatives;
        logic [31:0] pick [6];
        pick[0] = 32'h4000_0000; pick[1] = 32'h7FFF_FFFD; pick[2] = 32'h0000_0003;
        pick[3] = 32'h1234_5678; pick[4] = 32'h7FFF_FFFF; pick[5] = 32'h0000_0001;
        for (int i = 0; i < 6; i++) begin
            apply("R5 negate", -pick[i], -pick[i][15:0], -pick[i][7:0]);
            check_val("R5 sign", int'(s32), 1);
        end
    endtask

    task automatic t_sweep;
        logic [31:0] x;
        x = 32'h9E37_79B9;
        for (int i = 0; i < 256; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            apply("R7 R8 sweep", x, x[31:16], 8'(i));
        end
    endtask

    task automatic t_valid_gap;
        apply("R10 gap", 32'h5555_5555, 16'h5555, 8'h55);
        @(negedge clk);
        vld = 1'b0; w32 = 32'h4000_0000;
        @(negedge clk);
        check_val("R10 valid low", int'(v32 | v16 | v8), 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_one;
        t_specials;
        t_regimes;
        t_extremes;
        t_truncated_exp;
        t_negatives;
        t_sweep;
        t_valid_gap;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule